// File: doc/BRIEF.md
# Requeueing Instruction Pump

This block holds the instruction stream of one programmable dock. It is a circular FIFO of instruction words with a single on-deck slot at its head. The on-deck word is offered to an executor over a valid/ready handshake. When the executor takes a word, it also reports the current zero flag. The zero flag is the loop-finished indication, sampled before the word executes. A word whose one-shot bit is clear is requeueable. If a requeueable word is taken while the zero flag is low, the pump writes a copy of it back to its own tail. A program loop of several words can therefore circulate until the loop counter runs out.

New words come in on one enqueue port, and a hatch controls whether they may enter. A tail marker that arrives while the hatch is open closes the hatch, and the marker itself is dropped. The hatch opens again once a requeueable word is taken with the zero flag high. The same port carries torpedo tokens, which are instruction-port packets that carry no payload. A torpedo never enters the FIFO. It waits in a one-entry slot that the executor can see and clear.

Top module: `instr_pump`

## Requirements
- R1: After reset `od_valid_o` is 0, `torpedo_present_o` is 0, and the hatch is open, so `in_ready_o` is 1 for a plain word.
- R2: Word fields: bits [25:24] equal to 2'b11 mark a tail marker, and bit 23 is the one-shot bit. Accepted non-tail words are presented on deck in arrival order, and `od_valid_o` is high whenever the FIFO holds a word.
- R3: While the FIFO holds DEPTH words and no requeue happens, `in_ready_o` is 0 for a plain word.
- R4: When the executor takes a word with bit 23 clear while `z_flag_i` is 0, the same word is written to the FIFO tail and comes on deck again after the words queued ahead of it.
- R5: A word taken with bit 23 set, or taken with `z_flag_i` high, leaves the FIFO for good.
- R6: In a cycle with a requeue, an external plain word is refused (`in_ready_o` is 0). An external word accepted later is queued behind the requeued copy.
- R7: A tail marker is accepted while the hatch is open and is never placed in the FIFO. From the next cycle the hatch is sealed, and plain words see `in_ready_o` at 0.
- R8: While the hatch is sealed, a tail marker is also refused.
- R9: While the hatch is sealed, taking a word with bit 23 clear and `z_flag_i` high reopens it from the next cycle. Taking a one-shot word, or a word with `z_flag_i` low, leaves it sealed.
- R10: A word offered with `in_token_i` high is a torpedo. It is accepted into the waiting slot, `torpedo_present_o` rises on the next cycle, and the FIFO is unchanged.
- R11: While the slot is full, a further torpedo sees `in_ready_o` at 0. A `torpedo_consume_i` pulse empties the slot by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Enqueue port holds a packet |
| in_ready_o | output | 1 | Enqueue port accepts the packet |
| in_token_i | input | 1 | Packet is a torpedo token |
| in_word_i | input | 26 | Instruction word |
| od_valid_o | output | 1 | On-deck word is present |
| od_ready_i | input | 1 | Executor takes the on-deck word |
| od_word_o | output | 26 | On-deck word |
| z_flag_i | input | 1 | Zero flag from the executor, valid with `od_ready_i` |
| torpedo_present_o | output | 1 | Waiting slot holds a torpedo |
| torpedo_consume_i | input | 1 | Executor consumes the waiting torpedo |

## Verification
A requeue write and an external enqueue can both want the FIFO tail in the same cycle. The bench provokes this by holding a plain word on the enqueue port while the executor takes a requeueable word with the zero flag low. It expects the port to be refused in that cycle and accepted in the next, and it judges the outcome by the on-deck order: the requeued copy comes first, then the external word. A second overlap is a take that reopens the hatch while a word is waiting outside. The bench checks that the waiting word is refused until the cycle after the reopening take.

// File: rtl/instr_pump_pkg.sv
package instr_pump_pkg;
  localparam int unsigned INSTR_W  = 26;
  localparam int unsigned KIND_HI  = 25;
  localparam int unsigned KIND_LO  = 24;
  localparam int unsigned OS_BIT   = 23;
  localparam logic [1:0]  KIND_TAIL = 2'b11;

  typedef logic [INSTR_W-1:0] instr_t;

  function automatic logic is_tail(instr_t w);
    return w[KIND_HI:KIND_LO] == KIND_TAIL;
  endfunction

  function automatic logic is_one_shot(instr_t w);
    return w[OS_BIT];
  endfunction
endpackage

// File: rtl/pump_ring.sv
module pump_ring #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 26
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= bump(wptr_q);
      if (pop_i)  rptr_q <= bump(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= push_data_i;
  end

  assign head_o  = mem_q[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i |-> pop_i) else $error("ring overflow"); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o) else $error("ring underflow"); // R2
  AST_PUSH_POP_KEEPS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i |=> $stable(cnt_q)) else $error("fill drift"); // R4
endmodule

// File: rtl/pump_hatch.sv
module pump_hatch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seal_i,
  input  logic reopen_i,
  output logic open_o
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 open_q <= 1'b1;
    else if (open_q && seal_i)   open_q <= 1'b0;
    else if (!open_q && reopen_i) open_q <= 1'b1;
  end

  assign open_o = open_q;

  AST_SEAL_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o && seal_i |=> !open_o) else $error("seal ignored"); // R7
  AST_REOPEN_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_o && reopen_i |=> open_o) else $error("reopen ignored"); // R9
  AST_SEALED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_o && !reopen_i |=> !open_o) else $error("spurious open"); // R9
endmodule

// File: rtl/pump_torpedo.sv
module pump_torpedo (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic consume_i,
  output logic ready_o,
  output logic present_o
);
  logic full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  full_q <= 1'b0;
    else if (full_q && consume_i) full_q <= 1'b0;
    else if (!full_q && accept_i) full_q <= 1'b1;
  end

  assign ready_o   = !full_q;
  assign present_o = full_q;

  AST_TORP_ARRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> present_o) else $error("torpedo lost"); // R10
  AST_TORP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_o && !consume_i |=> present_o) else $error("torpedo vanished"); // R11
  AST_TORP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_o && consume_i |=> !present_o) else $error("torpedo stuck"); // R11
endmodule

// File: rtl/instr_pump.sv
module instr_pump
  import instr_pump_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic               in_token_i,
  input  logic [INSTR_W-1:0] in_word_i,
  output logic               od_valid_o,
  input  logic               od_ready_i,
  output logic [INSTR_W-1:0] od_word_o,
  input  logic               z_flag_i,
  output logic               torpedo_present_o,
  input  logic               torpedo_consume_i
);
  logic   empty, full, hatch_open, torp_ready;
  logic   fire, requeue, reopen_evt;
  logic   in_tail, ext_ok, ext_push, tail_acc, torp_acc, push;
  instr_t head, push_data;

  assign od_valid_o = !empty;
  assign od_word_o  = head;
  assign fire       = od_valid_o && od_ready_i;
  // zero flag is the pre-execution value supplied with the take
  assign requeue    = fire && !is_one_shot(head) && !z_flag_i;
  assign reopen_evt = fire && !is_one_shot(head) &&  z_flag_i;

  assign in_tail  = is_tail(in_word_i);
  // requeue owns the tail slot in its cycle
  assign ext_ok   = hatch_open && !full && !requeue;

  always_comb begin
    if (in_token_i)   in_ready_o = torp_ready;
    else if (in_tail) in_ready_o = hatch_open;
    else              in_ready_o = ext_ok;
  end

  assign torp_acc  = in_valid_i && in_token_i && torp_ready;
  assign tail_acc  = in_valid_i && !in_token_i && in_tail && hatch_open;
  assign ext_push  = in_valid_i && !in_token_i && !in_tail && ext_ok;
  assign push      = requeue || ext_push;
  assign push_data = requeue ? head : in_word_i;

  pump_ring #(.DEPTH(DEPTH), .W(INSTR_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (fire),
    .head_o      (head),
    .empty_o     (empty),
    .full_o      (full)
  );

  pump_hatch u_hatch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .seal_i   (tail_acc),
    .reopen_i (reopen_evt),
    .open_o   (hatch_open)
  );

  pump_torpedo u_torp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (torp_acc),
    .consume_i (torpedo_consume_i),
    .ready_o   (torp_ready),
    .present_o (torpedo_present_o)
  );

  AST_SEALED_NO_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hatch_open && in_valid_i && !in_token_i |-> !in_ready_o) else $error("sealed entry"); // R8
  AST_TAIL_NOT_QUEUED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_acc && !fire |=> $stable(empty)) else $error("tail queued"); // R7
  AST_TORP_NOT_QUEUED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    torp_acc |-> !ext_push) else $error("torpedo queued"); // R10
  AST_REQUEUE_BLOCKS_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    requeue && !in_token_i && !in_tail |-> !in_ready_o) else $error("ext during requeue"); // R6
endmodule

// File: tb/instr_pump_bench.sv
module instr_pump_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0, in_token = 1'b0;
  logic [25:0] in_word = '0;
  logic        od_ready = 1'b0, z_flag = 1'b0, consume = 1'b0;
  logic        in_ready, od_valid, torp_present;
  logic [25:0] od_word;
  int          errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_pump #(.DEPTH(DEPTH)) u_instr_pump (
    .clk_i (clk), .rst_ni (rst_ni),
    .in_valid_i (in_valid), .in_ready_o (in_ready), .in_token_i (in_token),
    .in_word_i (in_word), .od_valid_o (od_valid), .od_ready_i (od_ready),
    .od_word_o (od_word), .z_flag_i (z_flag),
    .torpedo_present_o (torp_present), .torpedo_consume_i (consume)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] mk(logic os, logic tail, logic [22:0] pl);
    return {tail ? 2'b11 : 2'b00, os, pl};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send(logic [25:0] w, logic tok);
    in_valid = 1'b1; in_word = w; in_token = tok; #1;
    while (!in_ready) step();
    step();
    in_valid = 1'b0; in_token = 1'b0;
  endtask

  task automatic take(string req, logic [25:0] exp, logic z);
    check({req, " on-deck valid"}, 32'(od_valid), 32'd1);
    check({req, " on-deck word"}, 32'(od_word), 32'(exp));
    od_ready = 1'b1; z_flag = z;
    step();
    od_ready = 1'b0; z_flag = 1'b0;
  endtask

  task automatic t_reset();
    in_word = mk(1'b1, 1'b0, 23'h1);
    #1;
    check("R1 od_valid", 32'(od_valid), 0);
    check("R1 torpedo", 32'(torp_present), 0);
    check("R1 ready", 32'(in_ready), 1);
  endtask

  task automatic t_order();
    send(mk(1'b1, 1'b0, 23'h11), 1'b0);
    send(mk(1'b1, 1'b0, 23'h22), 1'b0);
    send(mk(1'b1, 1'b0, 23'h33), 1'b0);
    take("R2", mk(1'b1, 1'b0, 23'h11), 1'b0);
    take("R2", mk(1'b1, 1'b0, 23'h22), 1'b0);
    take("R2", mk(1'b1, 1'b0, 23'h33), 1'b0);
    check("R5 one-shot gone", 32'(od_valid), 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) send(mk(1'b1, 1'b0, 23'(100 + i)), 1'b0);
    in_word = mk(1'b1, 1'b0, 23'h7); #1;
    check("R3 full ready", 32'(in_ready), 0);
    for (int i = 0; i < DEPTH; i++) take("R3", mk(1'b1, 1'b0, 23'(100 + i)), 1'b0);
  endtask

  task automatic t_requeue();
    send(mk(1'b0, 1'b0, 23'h51), 1'b0);
    send(mk(1'b1, 1'b0, 23'h52), 1'b0);
    take("R4", mk(1'b0, 1'b0, 23'h51), 1'b0);
    take("R4", mk(1'b1, 1'b0, 23'h52), 1'b0);
    take("R4 again", mk(1'b0, 1'b0, 23'h51), 1'b1);
    check("R5 z high drops", 32'(od_valid), 0);
  endtask

  task automatic t_priority();
    send(mk(1'b0, 1'b0, 23'h61), 1'b0);
    in_valid = 1'b1; in_token = 1'b0; in_word = mk(1'b1, 1'b0, 23'h62);
    od_ready = 1'b1; z_flag = 1'b0; #1;
    check("R6 refused", 32'(in_ready), 0);
    step();
    od_ready = 1'b0; #1;
    check("R6 later accepted", 32'(in_ready), 1);
    step();
    in_valid = 1'b0;
    take("R6 copy first", mk(1'b0, 1'b0, 23'h61), 1'b1);
    take("R6 then ext", mk(1'b1, 1'b0, 23'h62), 1'b0);
    check("R6 empty", 32'(od_valid), 0);
  endtask

  task automatic t_hatch();
    send(mk(1'b1, 1'b0, 23'h71), 1'b0);
    send(mk(1'b0, 1'b0, 23'h72), 1'b0);
    send(mk(1'b0, 1'b1, 23'h0), 1'b0);
    in_word = mk(1'b1, 1'b0, 23'h73); #1;
    check("R7 sealed", 32'(in_ready), 0);
    in_word = mk(1'b0, 1'b1, 23'h0); #1;
    check("R8 tail refused", 32'(in_ready), 0);
    take("R7 tail not queued", mk(1'b1, 1'b0, 23'h71), 1'b1);
    in_word = mk(1'b1, 1'b0, 23'h73); #1;
    check("R9 one-shot keeps sealed", 32'(in_ready), 0);
    take("R9", mk(1'b0, 1'b0, 23'h72), 1'b0);
    check("R9 z low keeps sealed", 32'(in_ready), 0);
    in_valid = 1'b1;
    od_ready = 1'b1; z_flag = 1'b1; #1;
    check("R9 refused in reopen cycle", 32'(in_ready), 0);
    step();
    od_ready = 1'b0; z_flag = 1'b0; #1;
    check("R9 reopened", 32'(in_ready), 1);
    step();
    in_valid = 1'b0;
    take("R9 entered", mk(1'b1, 1'b0, 23'h73), 1'b0);
  endtask

  task automatic t_torpedo();
    send(26'h3ffffff, 1'b1);
    check("R10 present", 32'(torp_present), 1);
    check("R10 not queued", 32'(od_valid), 0);
    in_valid = 1'b1; in_token = 1'b1; #1;
    check("R11 second refused", 32'(in_ready), 0);
    step();
    check("R11 still refused", 32'(in_ready), 0);
    in_valid = 1'b0; in_token = 1'b0;
    consume = 1'b1;
    step();
    consume = 1'b0;
    check("R11 cleared", 32'(torp_present), 0);
    in_token = 1'b1; #1;
    check("R11 ready again", 32'(in_ready), 1);
    in_token = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_order();
    t_full();
    t_requeue();
    t_priority();
    t_hatch();
    t_torpedo();
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule